// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block is the host-facing side of a PC-style keyboard controller. The host reaches it through byte-wide writes and reads on two addresses. Address 0 is the data port and address 1 is the command/status port. The block holds a one-byte output buffer with a full flag, and a configuration byte. It also holds a small pending-command state that decides where the next data-port write goes. It drives an interrupt request line, an A20 gate output, a CPU reset pulse and a keyboard-disable flag.

Keyboard-side traffic uses two valid/ready streams. Outbound, data-port writes that are not controller parameters are held in a one-entry register. That register raises `kbd_cmd_valid` until the keyboard responder takes the byte with `kbd_cmd_ready`. If a further forwarded write arrives while a byte is still held, the newer byte replaces it. Inbound, the responder offers bytes on `kbd_rsp_valid`/`kbd_rsp_data`. The block applies back-pressure by holding `kbd_rsp_ready` low while the output buffer is full, and also in any cycle when the controller itself loads the buffer. The responder must keep its byte stable until it is accepted.

Top module: `kbc_host_if`

## Requirements
- R1: A read with `host_addr`=1 returns 0x1C ORed with the full flag in bit 0, and it has no side effect.
- R2: A byte loaded into the output buffer sets the full flag. `irq1` is raised at that load only if bit 0 of the configuration byte is 1, and `irq1` is never high while the buffer is empty.
- R3: A read with `host_addr`=0 returns the buffered byte. After that clock edge the full flag and `irq1` are both low.
- R4: Command 0x20 copies the configuration byte into the output buffer. In the cycle it is written, it wins over a keyboard byte on offer, and `kbd_rsp_ready` is low in that cycle.
- R5: After command 0x60, the next data-port write replaces the configuration byte. That write is not forwarded to the keyboard side.
- R6: Command 0xAD sets `kbd_disabled` and command 0xAE clears it.
- R7: After command 0xD1, the next data-port write sets `a20_en` if it is 0xDF and clears it if it is 0xDD, and leaves it unchanged for any other value. That write clears the full flag and is not forwarded. `a20_en` changes on no other stimulus.
- R8: A command in 0xF0..0xFF with bit 0 = 0 holds `cpu_reset` high for exactly PULSE_CYCLES cycles, starting the cycle after the write. With bit 0 = 1 it gives no pulse. Either way it clears the pending state and the full flag.
- R9: After reset: configuration byte 0x01, output buffer empty, `irq1`, `a20_en`, `cpu_reset`, `kbd_disabled` and `kbd_cmd_valid` all low.
- R10: A command value not listed above changes no state: the status, the configuration byte, `a20_en`, `kbd_disabled` and the pending state all stay as they were.
- R11: A data-port write with nothing pending appears on `kbd_cmd_data` with `kbd_cmd_valid` high from the next cycle. It stays held and stable until accepted with `kbd_cmd_ready`, and a later forwarded write replaces it.
- R12: A keyboard byte is accepted only while the output buffer is empty (`kbd_rsp_ready` high), and the accepted byte becomes the buffered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | 0 = data port, 1 = command/status port |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe; side effects at the clock edge |
| host_rdata | output | 8 | Read data, combinational from the current state |
| kbd_cmd_valid | output | 1 | Forwarded byte available for the keyboard side |
| kbd_cmd_ready | input | 1 | Keyboard side takes the forwarded byte |
| kbd_cmd_data | output | 8 | Forwarded byte |
| kbd_rsp_valid | input | 1 | Keyboard side offers a byte |
| kbd_rsp_ready | output | 1 | Output buffer can take the offered byte |
| kbd_rsp_data | input | 8 | Offered byte |
| irq1 | output | 1 | Keyboard interrupt request |
| a20_en | output | 1 | A20 gate enable |
| cpu_reset | output | 1 | CPU reset pulse |
| kbd_disabled | output | 1 | Keyboard-disable flag |

## Verification
A write of command 0x20 and a byte offered by the keyboard responder can both try to fill the output buffer in the same cycle. The bench provokes this by raising `kbd_rsp_valid` in the same cycle as the 0x20 write. It then expects the configuration byte to be read back first, with the keyboard byte still held on its stream. After that read, the keyboard byte must be accepted and become the next byte read from the data port. A data-port read can also coincide with a load. The checker requires the buffer to be empty after any read that has no competing controller load.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_CFG  = 2'd1,
    PEND_OUTP = 2'd2
  } pend_e;

  typedef struct packed {
    logic rd_cfg;
    logic wr_cfg;
    logic kbd_off;
    logic kbd_on;
    logic outp;
    logic pulse;
  } cmd_dec_t;

  localparam byte_t CMD_RD_CFG  = 8'h20;
  localparam byte_t CMD_WR_CFG  = 8'h60;
  localparam byte_t CMD_KBD_OFF = 8'hAD;
  localparam byte_t CMD_KBD_ON  = 8'hAE;
  localparam byte_t CMD_OUTP    = 8'hD1;
  localparam logic [3:0] CMD_PULSE_HI = 4'hF;
  localparam byte_t STAT_BASE   = 8'h1C;
  localparam byte_t CFG_RST     = 8'h01;
  localparam byte_t OUTP_A20_ON  = 8'hDF;
  localparam byte_t OUTP_A20_OFF = 8'hDD;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic     en,
  input  byte_t    cmd,
  output cmd_dec_t dec
);
  always_comb begin
    dec         = '0;
    dec.rd_cfg  = en && (cmd == CMD_RD_CFG);
    dec.wr_cfg  = en && (cmd == CMD_WR_CFG);
    dec.kbd_off = en && (cmd == CMD_KBD_OFF);
    dec.kbd_on  = en && (cmd == CMD_KBD_ON);
    dec.outp    = en && (cmd == CMD_OUTP);
    dec.pulse   = en && (cmd[BYTE_W-1:BYTE_W-4] == CMD_PULSE_HI);
  end
endmodule

// File: rtl/kbc_obuf.sv
module kbc_obuf
  import kbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_load,
  input  byte_t ctrl_byte,
  input  logic  kb_valid,
  input  byte_t kb_data,
  output logic  kb_ready,
  input  logic  take,
  input  logic  flush,
  input  logic  irq_en,
  output byte_t obuf,
  output logic  full,
  output logic  irq
);
  logic  load;
  byte_t load_byte;

  assign kb_ready  = !full && !ctrl_load;
  assign load      = ctrl_load || (kb_valid && kb_ready);
  assign load_byte = ctrl_load ? ctrl_byte : kb_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obuf <= '0;
      full <= 1'b0;
      irq  <= 1'b0;
    end else if (load) begin
      obuf <= load_byte;
      full <= 1'b1;
      irq  <= irq_en;
    end else if (take || flush) begin
      full <= 1'b0;
      irq  <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_fwd_reg.sv
module kbc_fwd_reg
  import kbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  byte_t push_data,
  output logic  valid,
  input  logic  ready,
  output byte_t data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (push) begin
      valid <= 1'b1;
      data  <= push_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_pulse_gen.sv
module kbc_pulse_gen #(
  parameter int CYCLES = 1500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (trig)         cnt <= LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int PULSE_CYCLES = 1500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  output logic       kbd_cmd_valid,
  input  logic       kbd_cmd_ready,
  output logic [7:0] kbd_cmd_data,
  input  logic       kbd_rsp_valid,
  output logic       kbd_rsp_ready,
  input  logic [7:0] kbd_rsp_data,
  output logic       irq1,
  output logic       a20_en,
  output logic       cpu_reset,
  output logic       kbd_disabled
);
  logic     wr_cmd, wr_dat, rd_dat;
  cmd_dec_t dec;
  pend_e    pend_q;
  byte_t    cfg_q;
  byte_t    obuf_q;
  logic     obuf_full;
  logic     flush, pulse_trig;

  assign wr_cmd = host_wr &&  host_addr;
  assign wr_dat = host_wr && !host_addr;
  assign rd_dat = host_rd && !host_addr;

  kbc_cmd_decode u_dec (
    .en  (wr_cmd),
    .cmd (host_wdata),
    .dec (dec)
  );

  // pending-parameter state
  always_ff @(posedge clk) begin
    if (!rst_n)           pend_q <= PEND_NONE;
    else if (wr_cmd) begin
      if (dec.wr_cfg)     pend_q <= PEND_CFG;
      else if (dec.outp)  pend_q <= PEND_OUTP;
      else if (dec.pulse) pend_q <= PEND_NONE;
    end else if (wr_dat)  pend_q <= PEND_NONE;
  end

  // configuration byte, A20 gate, keyboard-disable flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q        <= CFG_RST;
      a20_en       <= 1'b0;
      kbd_disabled <= 1'b0;
    end else begin
      if (wr_dat && pend_q == PEND_CFG) cfg_q <= host_wdata;
      if (wr_dat && pend_q == PEND_OUTP) begin
        if (host_wdata == OUTP_A20_ON)       a20_en <= 1'b1;
        else if (host_wdata == OUTP_A20_OFF) a20_en <= 1'b0;
      end
      if (dec.kbd_off)     kbd_disabled <= 1'b1;
      else if (dec.kbd_on) kbd_disabled <= 1'b0;
    end
  end

  assign flush      = (wr_dat && pend_q == PEND_OUTP) || dec.pulse;
  assign pulse_trig = dec.pulse && !host_wdata[0];

  kbc_obuf u_obuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_load (dec.rd_cfg),
    .ctrl_byte (cfg_q),
    .kb_valid  (kbd_rsp_valid),
    .kb_data   (kbd_rsp_data),
    .kb_ready  (kbd_rsp_ready),
    .take      (rd_dat),
    .flush     (flush),
    .irq_en    (cfg_q[0]),
    .obuf      (obuf_q),
    .full      (obuf_full),
    .irq       (irq1)
  );

  kbc_fwd_reg u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_dat && pend_q == PEND_NONE),
    .push_data (host_wdata),
    .valid     (kbd_cmd_valid),
    .ready     (kbd_cmd_ready),
    .data      (kbd_cmd_data)
  );

  kbc_pulse_gen #(.CYCLES(PULSE_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (pulse_trig),
    .active (cpu_reset)
  );

  assign host_rdata = host_addr ? (STAT_BASE | {7'b0, obuf_full}) : obuf_q;
endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_addr,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       host_rd,
  input logic [7:0] host_rdata,
  input logic       kbd_cmd_valid,
  input logic       kbd_cmd_ready,
  input logic [7:0] kbd_cmd_data,
  input logic       kbd_rsp_ready,
  input logic       irq1,
  input logic       a20_en,
  input logic       cpu_reset,
  input logic       obuf_full,
  input logic [7:0] cfg_q
);
  p_status_fmt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr) |-> (host_rdata[7:1] == 7'h0E && host_rdata[0] == obuf_full));

  p_irq_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq1) |-> $past(cfg_q[0]));

  p_irq_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> obuf_full);

  p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_addr && obuf_full && !(host_wr && host_addr && host_wdata == 8'h20))
      |=> (!obuf_full && !irq1));

  p_ctrl_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr && host_wdata == 8'h20) |-> !kbd_rsp_ready);

  p_a20_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a20_en) |-> $past(host_wr && !host_addr));

  p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset) |-> $past(host_wr && host_addr && host_wdata[7:4] == 4'hF && !host_wdata[0]));

  p_fwd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_cmd_valid && !kbd_cmd_ready) |=> kbd_cmd_valid);

  p_fwd_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_cmd_valid && !kbd_cmd_ready && !(host_wr && !host_addr)) |=> $stable(kbd_cmd_data));

  p_rsp_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_rsp_ready |-> !obuf_full);
endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_addr     (host_addr),
  .host_wr       (host_wr),
  .host_wdata    (host_wdata),
  .host_rd       (host_rd),
  .host_rdata    (host_rdata),
  .kbd_cmd_valid (kbd_cmd_valid),
  .kbd_cmd_ready (kbd_cmd_ready),
  .kbd_cmd_data  (kbd_cmd_data),
  .kbd_rsp_ready (kbd_rsp_ready),
  .irq1          (irq1),
  .a20_en        (a20_en),
  .cpu_reset     (cpu_reset),
  .obuf_full     (obuf_full),
  .cfg_q         (cfg_q)
);

// File: tb/kbc_host_if_tb_top.sv
module kbc_host_if_tb_top;
  localparam int PULSE = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       kbd_cmd_valid, kbd_cmd_ready = 1'b0;
  logic [7:0] kbd_cmd_data;
  logic       kbd_rsp_valid = 1'b0, kbd_rsp_ready;
  logic [7:0] kbd_rsp_data = '0;
  logic       irq1, a20_en, cpu_reset, kbd_disabled;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  kbc_host_if #(.PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .kbd_cmd_valid(kbd_cmd_valid), .kbd_cmd_ready(kbd_cmd_ready),
    .kbd_cmd_data(kbd_cmd_data), .kbd_rsp_valid(kbd_rsp_valid),
    .kbd_rsp_ready(kbd_rsp_ready), .kbd_rsp_data(kbd_rsp_data),
    .irq1(irq1), .a20_en(a20_en), .cpu_reset(cpu_reset),
    .kbd_disabled(kbd_disabled)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b1, d);
    chk("R9 status after reset", d, 8'h1C);
    chk("R9 outputs after reset", {irq1, a20_en, cpu_reset, kbd_disabled, kbd_cmd_valid}, 5'b0);
    wr(1'b1, 8'h20);
    rd(1'b0, d);
    chk("R9 config reset value", d, 8'h01);
  endtask

  task automatic t_cfg_read();
    logic [7:0] d;
    wr(1'b1, 8'h20);
    chk("R2 irq1 with cfg bit0=1", irq1, 1'b1);
    rd(1'b1, d);
    chk("R1 status when full", d, 8'h1D);
    rd(1'b1, d);
    chk("R1 status read has no side effect", d, 8'h1D);
    rd(1'b0, d);
    chk("R4 cfg byte read back", d, 8'h01);
    chk("R3 irq1 withdrawn", irq1, 1'b0);
    rd(1'b1, d);
    chk("R3 full cleared", d, 8'h1C);
  endtask

  task automatic t_cfg_write();
    logic [7:0] d;
    wr(1'b1, 8'h60);
    wr(1'b0, 8'hA4);
    chk("R5 param not forwarded", kbd_cmd_valid, 1'b0);
    wr(1'b1, 8'h20);
    chk("R2 no irq1 with cfg bit0=0", irq1, 1'b0);
    rd(1'b1, d);
    chk("R2 full set without irq", d, 8'h1D);
    rd(1'b0, d);
    chk("R5 cfg replaced", d, 8'hA4);
    wr(1'b1, 8'h60);
    wr(1'b0, 8'h01);
  endtask

  task automatic t_disable();
    wr(1'b1, 8'hAD);
    chk("R6 disable set", kbd_disabled, 1'b1);
    wr(1'b1, 8'hAE);
    chk("R6 disable cleared", kbd_disabled, 1'b0);
  endtask

  task automatic t_a20();
    logic [7:0] d;
    wr(1'b1, 8'h20);
    wr(1'b1, 8'hD1);
    wr(1'b0, 8'hDF);
    chk("R7 A20 on", a20_en, 1'b1);
    chk("R7 not forwarded", kbd_cmd_valid, 1'b0);
    rd(1'b1, d);
    chk("R7 full cleared", d, 8'h1C);
    wr(1'b1, 8'hD1);
    wr(1'b0, 8'h12);
    chk("R7 other value keeps A20", a20_en, 1'b1);
    wr(1'b1, 8'hD1);
    wr(1'b0, 8'hDD);
    chk("R7 A20 off", a20_en, 1'b0);
  endtask

  task automatic t_pulse();
    logic [7:0] d;
    int n;
    wr(1'b1, 8'h20);
    wr(1'b1, 8'hFE);
    n = 0;
    while (cpu_reset && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk("R8 pulse length", n, PULSE);
    rd(1'b1, d);
    chk("R8 full cleared", d, 8'h1C);
    wr(1'b1, 8'hFF);
    chk("R8 odd command no pulse", cpu_reset, 1'b0);
    wr(1'b1, 8'h60);
    wr(1'b1, 8'hF1);
    wr(1'b0, 8'h77);
    chk("R8 pending cleared, write forwarded", {kbd_cmd_valid, kbd_cmd_data}, {1'b1, 8'h77});
    wr(1'b1, 8'h20);
    rd(1'b0, d);
    chk("R8 cfg untouched by dropped param", d, 8'h01);
    kbd_cmd_ready = 1'b1;
    @(negedge clk);
    kbd_cmd_ready = 1'b0;
  endtask

  task automatic t_unknown();
    logic [7:0] d;
    wr(1'b1, 8'hD1);
    wr(1'b1, 8'hA7);
    chk("R10 no state change", {a20_en, kbd_disabled, cpu_reset}, 3'b0);
    rd(1'b1, d);
    chk("R10 status unchanged", d, 8'h1C);
    wr(1'b0, 8'hDF);
    chk("R10 pending kept", a20_en, 1'b1);
    wr(1'b1, 8'h20);
    rd(1'b0, d);
    chk("R10 cfg unchanged", d, 8'h01);
  endtask

  task automatic t_forward();
    wr(1'b0, 8'h55);
    chk("R11 forward valid", {kbd_cmd_valid, kbd_cmd_data}, {1'b1, 8'h55});
    repeat (3) @(negedge clk);
    chk("R11 held until ready", {kbd_cmd_valid, kbd_cmd_data}, {1'b1, 8'h55});
    wr(1'b0, 8'h66);
    chk("R11 replaced", {kbd_cmd_valid, kbd_cmd_data}, {1'b1, 8'h66});
    kbd_cmd_ready = 1'b1;
    @(negedge clk);
    chk("R11 taken", kbd_cmd_valid, 1'b0);
    kbd_cmd_ready = 1'b0;
  endtask

  task automatic t_rsp();
    logic [7:0] d;
    @(negedge clk);
    kbd_rsp_valid = 1'b1; kbd_rsp_data = 8'hAB;
    @(negedge clk);
    kbd_rsp_valid = 1'b0;
    chk("R12 ready low when full", kbd_rsp_ready, 1'b0);
    chk("R2 irq1 on keyboard byte", irq1, 1'b1);
    rd(1'b0, d);
    chk("R12 byte buffered", d, 8'hAB);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    int n;
    @(negedge clk);
    kbd_rsp_valid = 1'b1; kbd_rsp_data = 8'h3C;
    host_wr = 1'b1; host_addr = 1'b1; host_wdata = 8'h20;
    #1 chk("R4 ready low during 0x20", kbd_rsp_ready, 1'b0);
    @(negedge clk);
    host_wr = 1'b0;
    rd(1'b0, d);
    chk("R4 controller byte first", d, 8'h01);
    n = 0;
    while (!kbd_rsp_ready && n < 20) begin
      n++;
      @(negedge clk);
    end
    @(negedge clk);
    kbd_rsp_valid = 1'b0;
    rd(1'b0, d);
    chk("R12 keyboard byte after collision", d, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_read();
    t_cfg_write();
    t_disable();
    t_a20();
    t_pulse();
    t_unknown();
    t_forward();
    t_rsp();
    t_collide();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule